// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer split across two clocks. A bus-side register file runs on the bus clock and takes single-cycle writes and combinational reads. A 12-bit down-counter runs on a separate slow clock. Software does not set control bits. It writes 16-bit key words to a command register. One key opens the configuration registers for writing. Any unrecognised key, or the zero key, closes them again. One key starts the countdown and one key reloads it.

Every configuration register has a bus-side copy that software reads back. A toggle handshake carries each new value into the slow domain. A busy flag in the status register stays set until the slow side has acknowledged the value. Once the watchdog is started it cannot be stopped by software. Each time the counter runs out, the block emits a one-cycle reset request and reloads itself. An early-warning interrupt can be raised when the count reaches a programmed compare value.

Top module: `kwdt`

## Requirements
- R1: After reset the following read back. Prescaler (offset 0x004) reads 0. Reload (0x008) reads 0xFFF. Status (0x00C) reads 0. Early-warning control (0x014) reads 0. `ew_irq` and `wdg_rst_req` are low.
- R2: The key register is at offset 0x000 and its key is taken from bits 15:0. After key 0x5555, writes are accepted to the prescaler (bits 3:0), to reload (bits 11:0) and to early-warning control (bit 15 enable, bits 11:0 compare). While locked, the same writes leave the readback unchanged.
- R3: Key 0x0000 or any undefined key value relocks the registers. Keys 0xAAAA and 0xCCCC leave the lock state as it was.
- R4: An accepted write sets a status pending bit on the following cycle. The bit is 0 for the prescaler, 1 for reload and 3 for early-warning control. The bit clears by itself within 64 bus cycles. Status bit 2 always reads 0.
- R5: A write to a register whose pending bit is set is ignored.
- R6: Status bit 8 is 0 before start. It reads 1 from the cycle after key 0xCCCC is written and stays 1 until reset.
- R7: With reload value R and prescaler code p, the slow clock is divided by 2^(p+2). Codes 6 and above divide by 256. After start, `wdg_rst_req` pulses (R+1)·divider slow cycles later, within a few cycles of synchronisation delay. It then repeats exactly every (R+1)·divider slow cycles.
- R8: Writing key 0xAAAA while running reloads the counter. Refreshing at intervals shorter than the timeout produces no reset request.
- R9: `wdg_rst_req` is never asserted before start. Each assertion lasts exactly one slow-clock cycle.
- R10: With the enable bit set, `ew_irq` rises when the counter steps to the compare value. It stays high until bit 14 of offset 0x014 is written as 1, and this clear works even while the registers are locked. With the enable bit clear, `ew_irq` never rises.
- R11: If an early-warning event and a clear write fall in the same bus cycle, the event wins and `ew_irq` is high afterwards.
- R12: Offset 0x3F4 returns revision 0x31 in bits 7:0 and zero above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register-bus clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| slow_clk | input | 1 | Counter clock |
| slow_rst_n | input | 1 | Synchronous active-low reset, slow domain |
| wdg_rst_req | output | 1 | One-cycle reset request on expiry, slow domain |
| ew_irq | output | 1 | Early-warning interrupt level, bus domain |

## Verification
The early-warning event comes back from the slow domain, and a clear write arrives from the bus. Both can land in the same bus cycle. To force the collision, the bench holds a clear write on the bus every cycle for longer than one full countdown period. Any event that crosses over is then bound to coincide with a clear. The bench passes the run only if `ew_irq` is seen high between edges during that window. If the clear had priority, the line would stay low throughout.

// File: rtl/kwdt_pkg.sv
// Shared constants for the key-protected watchdog: register offsets,
// key words and status bit positions.
package kwdt_pkg;
    localparam logic [11:0] OFF_KEY = 12'h000;
    localparam logic [11:0] OFF_PRE = 12'h004;
    localparam logic [11:0] OFF_RLD = 12'h008;
    localparam logic [11:0] OFF_STS = 12'h00C;
    localparam logic [11:0] OFF_EWC = 12'h014;
    localparam logic [11:0] OFF_VER = 12'h3F4;

    localparam logic [15:0] KEY_OPEN    = 16'h5555;
    localparam logic [15:0] KEY_CLOSE   = 16'h0000;
    localparam logic [15:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [15:0] KEY_GO      = 16'hCCCC;

    localparam int STS_PRE_BUSY = 0;
    localparam int STS_RLD_BUSY = 1;
    localparam int STS_WIN_BUSY = 2;
    localparam int STS_EW_BUSY  = 3;
    localparam int STS_RUNNING  = 8;

    localparam int EWC_ENABLE = 15;
    localparam int EWC_CLEAR  = 14;
endpackage

// File: rtl/kwdt_xfer.sv
// Holds one configuration register in the bus domain and carries it to the
// slow domain with a toggle request and acknowledge handshake.
// Assumes: load is only asserted while busy is low, so data_q is stable
// for as long as the slow side may sample it.
module kwdt_xfer #(
    parameter int          W       = 12,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         bclk,
    input  logic         brst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] data_q,
    output logic         busy,
    input  logic         sclk,
    input  logic         srst_n,
    output logic [W-1:0] dout
);
    logic req_t, ack_s1, ack_s2;
    logic req_s1, req_s2, ack_t;

    assign busy = req_t ^ ack_s2;

    // Bus side: capture new value, flip request, resynchronise acknowledge.
    always_ff @(posedge bclk) begin
        if (!brst_n) begin
            data_q <= RST_VAL;
            req_t  <= 1'b0;
            ack_s1 <= 1'b0;
            ack_s2 <= 1'b0;
        end else begin
            ack_s1 <= ack_t;
            ack_s2 <= ack_s1;
            if (load) begin
                data_q <= din;
                req_t  <= ~req_t;
            end
        end
    end

    // Slow side: resynchronise request, take the value, return acknowledge.
    always_ff @(posedge sclk) begin
        if (!srst_n) begin
            req_s1 <= 1'b0;
            req_s2 <= 1'b0;
            ack_t  <= 1'b0;
            dout   <= RST_VAL;
        end else begin
            req_s1 <= req_t;
            req_s2 <= req_s1;
            if (req_s2 != ack_t) begin
                dout  <= data_q;
                ack_t <= req_s2;
            end
        end
    end

    // R5: the value being handed over must not move while busy.
    a_r5_hold_while_busy: assert property (@(posedge bclk) disable iff (!brst_n)
        busy |=> $stable(data_q));
endmodule

// File: rtl/kwdt_pulse_sync.sv
// Moves a single-cycle pulse between clock domains through a toggle and a
// three-flop synchroniser. Assumes source pulses are spaced wider than
// three destination cycles.
module kwdt_pulse_sync (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    logic tog;
    logic [2:0] sync_q;

    // Flip the toggle on every source pulse.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) tog <= 1'b0;
        else if (src_pulse) tog <= ~tog;
    end

    // Shift the toggle through the destination synchroniser.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) sync_q <= '0;
        else sync_q <= {sync_q[1:0], tog};
    end

    assign dst_pulse = sync_q[2] ^ sync_q[1];
endmodule

// File: rtl/kwdt_core.sv
// Slow-domain countdown. A power-of-two prescaler feeds a down-counter that
// loads the reload value on start or refresh. On expiry the counter emits a
// one-cycle reset request and reloads. It also flags when the count steps
// onto the early-warning compare value.
// Assumes the smallest divider is 4, so ticks never fall on adjacent cycles.
module kwdt_core #(
    parameter int CNT_W   = 12,
    parameter int PRE_W   = 4,
    parameter int DIV_LOG = 8
) (
    input  logic             sclk,
    input  logic             srst_n,
    input  logic             start_p,
    input  logic             refresh_p,
    input  logic [PRE_W-1:0] pre_code,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             ew_en,
    input  logic [CNT_W-1:0] ew_cmp,
    output logic             rst_req,
    output logic             ew_evt
);
    logic               running;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   cnt_dec;
    logic [DIV_LOG-1:0] pdiv;
    logic [DIV_LOG-1:0] mask;
    logic [PRE_W:0]     lg;
    logic               tick;

    assign lg      = {1'b0, pre_code} + (PRE_W+1)'(2);
    assign cnt_dec = cnt - 1'b1;

    // Divider mask: the low lg bits set, saturating at DIV_LOG bits.
    always_comb begin
        for (int i = 0; i < DIV_LOG; i++) mask[i] = (32'(lg) > i);
    end

    assign tick = running && ((pdiv & mask) == mask);

    // Countdown, expiry and early-warning detection.
    always_ff @(posedge sclk) begin
        if (!srst_n) begin
            running <= 1'b0;
            cnt     <= '1;
            pdiv    <= '0;
            rst_req <= 1'b0;
            ew_evt  <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            ew_evt  <= 1'b0;
            pdiv    <= pdiv + 1'b1;
            if (start_p || (refresh_p && running)) begin
                running <= 1'b1;
                cnt     <= reload_val;
                pdiv    <= '0;
            end else if (tick) begin
                if (cnt == '0) begin
                    rst_req <= 1'b1;
                    cnt     <= reload_val;
                    ew_evt  <= ew_en && (reload_val == ew_cmp);
                end else begin
                    cnt    <= cnt_dec;
                    ew_evt <= ew_en && (cnt_dec == ew_cmp);
                end
            end
        end
    end

    // R9: the request lasts exactly one slow cycle.
    a_r9_one_cycle: assert property (@(posedge sclk) disable iff (!srst_n)
        rst_req |=> !rst_req);
    // R9: no request until the countdown has been started.
    a_r9_not_before_start: assert property (@(posedge sclk) disable iff (!srst_n)
        !running |-> !rst_req);
endmodule

// File: rtl/kwdt.sv
// Top of the key-protected watchdog. It decodes key words and keeps the
// lock, the running flag and the interrupt flag. It holds the configuration
// copies for readback and hands them to the slow-domain countdown.
// Assumes one write per bus cycle and clocks that both keep running.
module kwdt #(
    parameter int          ADDR_W  = 12,
    parameter int          CNT_W   = 12,
    parameter int          PRE_W   = 4,
    parameter int          DIV_LOG = 8,
    parameter logic [7:0]  REV     = 8'h31
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              slow_clk,
    input  logic              slow_rst_n,
    output logic              wdg_rst_req,
    output logic              ew_irq
);
    import kwdt_pkg::*;

    localparam int EW_W = CNT_W + 1;

    logic [15:0] kval;
    logic key_wr, unlocked, running_flag;
    logic start_b, refresh_b, start_s, refresh_s;
    logic pre_load, rld_load, ew_load, ew_clr;
    logic pre_busy, rld_busy, ew_busy;
    logic [PRE_W-1:0] pre_q, pre_s;
    logic [CNT_W-1:0] rld_q, rld_s;
    logic [EW_W-1:0]  ew_q, ew_s;
    logic ew_evt_s, ew_evt_b;
    logic unused_wdata;

    assign kval      = reg_wdata[15:0];
    assign key_wr    = reg_we && (reg_addr == ADDR_W'(OFF_KEY));
    assign start_b   = key_wr && (kval == KEY_GO);
    assign refresh_b = key_wr && (kval == KEY_REFRESH);
    assign pre_load  = reg_we && (reg_addr == ADDR_W'(OFF_PRE)) && unlocked && !pre_busy;
    assign rld_load  = reg_we && (reg_addr == ADDR_W'(OFF_RLD)) && unlocked && !rld_busy;
    assign ew_load   = reg_we && (reg_addr == ADDR_W'(OFF_EWC)) && unlocked && !ew_busy;
    assign ew_clr    = reg_we && (reg_addr == ADDR_W'(OFF_EWC)) && reg_wdata[EWC_CLEAR];
    assign unused_wdata = &{reg_wdata[31:16], reg_wdata[13:CNT_W]};

    // Lock state and running flag from key words.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            unlocked     <= 1'b0;
            running_flag <= 1'b0;
        end else begin
            if (key_wr) begin
                if (kval == KEY_OPEN) unlocked <= 1'b1;
                else if (kval != KEY_REFRESH && kval != KEY_GO) unlocked <= 1'b0;
            end
            if (start_b) running_flag <= 1'b1;
        end
    end

    // Interrupt flag: a returning event takes priority over a clear.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) ew_irq <= 1'b0;
        else ew_irq <= ew_evt_b || (ew_irq && !ew_clr);
    end

    kwdt_xfer #(.W(PRE_W), .RST_VAL('0)) u_pre (
        .bclk(bus_clk), .brst_n(bus_rst_n), .load(pre_load), .din(reg_wdata[PRE_W-1:0]),
        .data_q(pre_q), .busy(pre_busy), .sclk(slow_clk), .srst_n(slow_rst_n), .dout(pre_s));

    kwdt_xfer #(.W(CNT_W), .RST_VAL('1)) u_rld (
        .bclk(bus_clk), .brst_n(bus_rst_n), .load(rld_load), .din(reg_wdata[CNT_W-1:0]),
        .data_q(rld_q), .busy(rld_busy), .sclk(slow_clk), .srst_n(slow_rst_n), .dout(rld_s));

    kwdt_xfer #(.W(EW_W), .RST_VAL('0)) u_ewc (
        .bclk(bus_clk), .brst_n(bus_rst_n), .load(ew_load),
        .din({reg_wdata[EWC_ENABLE], reg_wdata[CNT_W-1:0]}),
        .data_q(ew_q), .busy(ew_busy), .sclk(slow_clk), .srst_n(slow_rst_n), .dout(ew_s));

    kwdt_pulse_sync u_go (
        .src_clk(bus_clk), .src_rst_n(bus_rst_n), .src_pulse(start_b),
        .dst_clk(slow_clk), .dst_rst_n(slow_rst_n), .dst_pulse(start_s));

    kwdt_pulse_sync u_refresh (
        .src_clk(bus_clk), .src_rst_n(bus_rst_n), .src_pulse(refresh_b),
        .dst_clk(slow_clk), .dst_rst_n(slow_rst_n), .dst_pulse(refresh_s));

    kwdt_pulse_sync u_ew (
        .src_clk(slow_clk), .src_rst_n(slow_rst_n), .src_pulse(ew_evt_s),
        .dst_clk(bus_clk), .dst_rst_n(bus_rst_n), .dst_pulse(ew_evt_b));

    kwdt_core #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DIV_LOG(DIV_LOG)) u_core (
        .sclk(slow_clk), .srst_n(slow_rst_n), .start_p(start_s), .refresh_p(refresh_s),
        .pre_code(pre_s), .reload_val(rld_s), .ew_en(ew_s[CNT_W]), .ew_cmp(ew_s[CNT_W-1:0]),
        .rst_req(wdg_rst_req), .ew_evt(ew_evt_s));

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(OFF_PRE): reg_rdata[PRE_W-1:0] = pre_q;
            ADDR_W'(OFF_RLD): reg_rdata[CNT_W-1:0] = rld_q;
            ADDR_W'(OFF_STS): begin
                reg_rdata[STS_PRE_BUSY] = pre_busy;
                reg_rdata[STS_RLD_BUSY] = rld_busy;
                reg_rdata[STS_WIN_BUSY] = 1'b0;
                reg_rdata[STS_EW_BUSY]  = ew_busy;
                reg_rdata[STS_RUNNING]  = running_flag;
            end
            ADDR_W'(OFF_EWC): begin
                reg_rdata[EWC_ENABLE]  = ew_q[CNT_W];
                reg_rdata[CNT_W-1:0]   = ew_q[CNT_W-1:0];
            end
            ADDR_W'(OFF_VER): reg_rdata[7:0] = REV;
            default: reg_rdata = '0;
        endcase
    end

    // R6: once started, the running flag never drops.
    a_r6_run_sticky: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        running_flag |=> running_flag);
    // R3: any key other than open, refresh or start leaves the registers locked.
    a_r3_relock: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (key_wr && kval != KEY_OPEN && kval != KEY_REFRESH && kval != KEY_GO) |=> !unlocked);
    // R11: an arriving event always leaves the interrupt set.
    a_r11_event_wins: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        ew_evt_b |=> ew_irq);
endmodule

// File: tb/kwdt_test.sv
`timescale 1ns/1ps
module kwdt_test;
    logic        bus_clk = 1'b0, slow_clk = 1'b0;
    logic        bus_rst_n = 1'b0, slow_rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wdg_rst_req, ew_irq;

    kwdt uut (.bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
              .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slow_clk(slow_clk),
              .slow_rst_n(slow_rst_n), .wdg_rst_req(wdg_rst_req), .ew_irq(ew_irq));

    always #2 bus_clk = ~bus_clk;
    always #8 slow_clk = ~slow_clk;

    int checks = 0, errors = 0, cyc = 0;
    int scyc = 0, pulses = 0, last_t = 0, prev_t = 0, width_err = 0;
    logic prev_high = 1'b0, storm = 1'b0, seen = 1'b0, done = 1'b0;
    logic [31:0] rd;

    typedef struct packed {
        logic [15:0] key;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;
    // key written first, then a register write, then the expected readback
    localparam vec_t VEC [7] = '{
        '{16'h0000, 12'h004, 32'h0000_0003, 32'h0000_0000},  // R2 locked
        '{16'h5555, 12'h004, 32'h0000_0003, 32'h0000_0003},  // R2 open
        '{16'h5555, 12'h008, 32'h0000_0123, 32'h0000_0123},  // R2
        '{16'h1234, 12'h008, 32'h0000_0456, 32'h0000_0123},  // R3 undefined key
        '{16'h5555, 12'h014, 32'h0000_8005, 32'h0000_8005},  // R2 ew ctrl
        '{16'hAAAA, 12'h008, 32'h0000_0077, 32'h0000_0077},  // R3 refresh keeps open
        '{16'h0000, 12'h004, 32'h0000_0005, 32'h0000_0003}   // R3 close
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge bus_clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge bus_clk); reg_we = 1'b0;
    endtask

    task automatic rdreg(input logic [11:0] a, output logic [31:0] d);
        @(negedge bus_clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic wait_idle(output logic [31:0] st);
        for (int i = 0; i < 64; i++) begin
            rdreg(12'h00C, st);
            if ((st & 32'h0F) == 0) break;
        end
    endtask

    task automatic wait_pulse();
        int n0 = pulses;
        for (int i = 0; i < 3000; i++) begin
            @(negedge slow_clk);
            if (pulses > n0) break;
        end
    endtask

    // Slow-domain monitor: count reset requests and their widths.
    always @(negedge slow_clk) begin
        scyc++;
        if (wdg_rst_req) begin
            pulses++;
            prev_t = last_t;
            last_t = scyc;
            if (prev_high) width_err++;
        end
        prev_high = wdg_rst_req;
    end

    // Bus-domain monitor for the clear storm.
    always @(negedge bus_clk) if (storm && ew_irq) seen = 1'b1;

    // Watchdog on the run length.
    always @(posedge bus_clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t0, p0;
        repeat (10) @(negedge bus_clk);
        bus_rst_n = 1'b1; slow_rst_n = 1'b1;
        repeat (2) @(negedge bus_clk);

        // R1 reset state
        rdreg(12'h004, rd); chk("R1 prescaler", rd, 32'h0);
        rdreg(12'h008, rd); chk("R1 reload", rd, 32'hFFF);
        rdreg(12'h00C, rd); chk("R1 status", rd, 32'h0);
        rdreg(12'h014, rd); chk("R1 ew ctrl", rd, 32'h0);
        chk("R1 irq", {31'b0, ew_irq}, 32'h0);
        chk("R1 rst_req", {31'b0, wdg_rst_req}, 32'h0);

        // Vector table: key, write, settle, readback (R2/R3)
        foreach (VEC[i]) begin
            wr(12'h000, {16'h0, VEC[i].key});
            wr(VEC[i].addr, VEC[i].data);
            wait_idle(rd);
            rdreg(VEC[i].addr, rd);
            chk($sformatf("R2/R3 vector %0d", i), rd, VEC[i].exp);
        end

        // R4 pending flag sets then clears; bit 2 stays 0
        wr(12'h000, 32'h5555);
        wr(12'h008, 32'h010);
        rdreg(12'h00C, rd); chk("R4 reload pending set", rd & 32'h2, 32'h2);
        wait_idle(rd); chk("R4 pending cleared", rd & 32'hF, 32'h0);

        // R5 a write while pending is ignored
        @(negedge bus_clk); reg_we = 1'b1; reg_addr = 12'h008; reg_wdata = 32'h020;
        @(negedge bus_clk); reg_wdata = 32'h030;
        @(negedge bus_clk); reg_we = 1'b0;
        wait_idle(rd);
        rdreg(12'h008, rd); chk("R5 write during pending ignored", rd, 32'h020);
        wr(12'h004, 32'h0);
        wait_idle(rd);
        wr(12'h000, 32'h0);

        // R9 nothing before start; R6 flag still clear
        repeat (300) @(negedge slow_clk);
        chk("R9 no request before start", pulses, 0);
        rdreg(12'h00C, rd); chk("R6 not running", rd & 32'h100, 32'h0);

        // R6 start, R7 first timeout: (32+1)*4 = 132 slow cycles
        wr(12'h000, 32'hCCCC);
        t0 = scyc;
        rdreg(12'h00C, rd); chk("R6 running after start", rd & 32'h100, 32'h100);
        wait_pulse();
        chk("R7 first timeout in window",
            {31'b0, (last_t - t0 >= 132) && (last_t - t0 <= 140)}, 32'h1);
        wait_pulse();
        chk("R7 period", last_t - prev_t, 132);

        // R10 interrupt set by compare 5, cleared while locked
        chk("R10 irq raised", {31'b0, ew_irq}, 32'h1);
        wr(12'h014, 32'h4000);
        chk("R10 irq cleared", {31'b0, ew_irq}, 32'h0);
        rdreg(12'h014, rd); chk("R10 locked clear keeps config", rd, 32'h8005);

        // R11 clear held every cycle across a full period
        @(negedge bus_clk); reg_we = 1'b1; reg_addr = 12'h014; reg_wdata = 32'h4000; storm = 1'b1;
        repeat (600) @(negedge bus_clk);
        storm = 1'b0; reg_we = 1'b0;
        chk("R11 event beats clear", {31'b0, seen}, 32'h1);

        // R8 periodic refresh holds off expiry
        wait_pulse();
        p0 = pulses;
        for (int k = 0; k < 20; k++) begin
            repeat (50) @(negedge slow_clk);
            wr(12'h000, 32'hAAAA);
        end
        chk("R8 no request while refreshed", pulses - p0, 0);

        // R10 disabled compare raises nothing
        wr(12'h000, 32'h5555);
        wr(12'h014, 32'h0005);
        wait_idle(rd);
        wr(12'h000, 32'h0);
        wr(12'h014, 32'h4000);
        p0 = pulses;
        repeat (300) @(negedge slow_clk);
        chk("R10 disabled no irq", {31'b0, ew_irq}, 32'h0);
        chk("R10 counter still expiring", {31'b0, (pulses - p0) >= 2}, 32'h1);

        // R7 saturating prescaler code 9, reload 3: 4*256 = 1024
        wr(12'h000, 32'h5555);
        wr(12'h004, 32'h9);
        wr(12'h008, 32'h3);
        wait_idle(rd);
        wr(12'h000, 32'hAAAA);
        wait_pulse();
        wait_pulse();
        wait_pulse();
        chk("R7 divide saturates at 256", last_t - prev_t, 1024);

        // R9 width, R12 version, R6 sticky
        chk("R9 one-cycle request", width_err, 0);
        rdreg(12'h3F4, rd); chk("R12 version", rd, 32'h31);
        rdreg(12'h00C, rd); chk("R6 still running", rd & 32'h100, 32'h100);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule